// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is the bus-facing side of a small byte-wide memory that a system reaches over a two-wire serial bus. It oversamples the clock and data lines on its own system clock and finds the bus conditions and bit edges. It then checks each control byte against a fixed device-type code and three strap inputs, and serves writes and reads of an internal byte array. Several copies with different straps can share one bus. The block never drives the data line high. Its only bus output is a pull-low enable, which the pad logic turns into an open-drain driver.

A write transaction carries a two-byte address and then one or more data bytes. The bytes go into a one-page buffer and are stored in the array only after the STOP. During a fixed busy window after that STOP the block stays off the bus, and a master finds out that the store has finished by polling with control bytes. A read transaction starts at the current address pointer, or at a new address set by an address-only write followed by a repeated START, and it continues byte after byte while the master acknowledges. A write-protect input guards the upper quarter of the array.

Top module: `i2c_serial_mem`

## Requirements
- R1: After reset and whenever no transaction is addressed to the block, `sda_low` stays 0. Bytes clocked without a preceding START get no acknowledge.
- R2: The control byte carries the device type in bits 7..4, the strap value in bits 3..1 and the direction in bit 0 (1 = read), most significant bit first. It is acknowledged only when bits 7..4 equal 4'b1010 and bits 3..1 equal `addr_strap`. Any other byte is left unacknowledged and the block goes idle.
- R3: A write's two address bytes arrive high byte first. Only the low `MEM_AW` bits of the 16 received bits select a location, and the other bits have no effect.
- R4: Every data byte of a write is acknowledged. After each byte the low 5 address bits advance modulo 32 and the upper address bits do not change, so a long write wraps inside its 32-byte page.
- R5: Buffered data reaches the array only after STOP. For `BUSY_CYC` cycles after that STOP (never fewer than 32) every control byte is left unacknowledged. Once the window ends, control bytes are acknowledged again and the new data reads back.
- R6: A read returns the byte at the current address, most significant bit first. `sda_low` changes only in the cycle after the block sees an SCL falling edge, a START or a STOP.
- R7: A sequential read advances the address by one after each byte and wraps from the last location to 0. After the master's NACK the line is released, and the next read without a new address continues at the location after the last byte sent.
- R8: While `wp_in` is 1, data bytes aimed at addresses whose top two bits are 2'b11 are acknowledged but not stored, and lower addresses are stored. While `wp_in` is 0 every address is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired bus value) |
| sda_low | output | 1 | 1 = pull the data line low, 0 = release it |
| addr_strap | input | 3 | Board strap value compared with control byte bits 3..1 |
| wp_in | input | 1 | Write guard for the upper quarter of the array |

## Verification
Most internal faults reach the ports within one byte of the bus. A bad bit counter or decode shows up as an acknowledge in the wrong slot, or a missing one, on the ninth clock of that same byte. A wrong address pointer or page wrap stays hidden until the read-back of an affected location returns a value other than the one the bench model predicts. A busy counter that is too short or too long shows up as a control byte acknowledged or refused in a place the bench does not expect. A write guard that leaks changes a protected byte, which appears only on a later read of that address.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } slv_state_e;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction

    function automatic logic is_guarded(input logic [1:0] top2, input logic wp);
        return wp && (top2 == 2'b11);
    endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import i2cmem_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC-1:0] scl_pipe, sda_pipe;
    logic            scl_q, sda_q, scl_s, sda_s;

    assign scl_s = scl_pipe[SYNC-1];
    assign sda_s = sda_pipe[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_page_store.sv
module i2c_page_store #(
    parameter int AW       = 10,
    parameter int PAW      = 5,
    parameter int BUSY_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_clr,
    input  logic              wb_en,
    input  logic [PAW-1:0]    wb_off,
    input  logic [7:0]        wb_data,
    input  logic              commit,
    input  logic [AW-PAW-1:0] base,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int PAGE  = 1 << PAW;
    localparam int DEPTH = 1 << AW;
    localparam int WIN   = (BUSY_CYC > PAGE) ? BUSY_CYC : PAGE;
    localparam int CW    = $clog2(WIN + 1);
    localparam logic [CW-1:0] CNT_ONE = 1;
    localparam logic [PAW:0]  IDX_ONE = 1;

    logic [7:0]        mem  [DEPTH];
    logic [7:0]        pbuf [PAGE];
    logic [PAGE-1:0]   pval;
    logic [CW-1:0]     busy_cnt;
    logic [AW-PAW-1:0] base_q;
    logic [PAW:0]      cidx;
    logic [PAW-1:0]    cofs;
    logic              mem_we;

    assign busy    = (busy_cnt != '0);
    assign cofs    = cidx[PAW-1:0];
    assign mem_we  = busy && !cidx[PAW] && pval[cofs];
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            pval     <= '0;
            busy_cnt <= '0;
            base_q   <= '0;
            cidx     <= '0;
        end else begin
            if (buf_clr)
                pval <= '0;
            else if (wb_en)
                pval[wb_off] <= 1'b1;
            if (commit) begin
                busy_cnt <= CW'(WIN);
                base_q   <= base;
                cidx     <= '0;
            end else if (busy) begin
                busy_cnt <= busy_cnt - CNT_ONE;
                if (!cidx[PAW])
                    cidx <= cidx + IDX_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wb_en)
            pbuf[wb_off] <= wb_data;
    end

    always_ff @(posedge clk) begin
        if (mem_we)
            mem[{base_q, cofs}] <= pbuf[cofs];
    end

    // R5: the controller never fills the buffer while a store is in progress
    assert_no_fill_busy_R5: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !busy);

    // R5: a new store is requested only once the previous window has closed
    assert_commit_ready_R5: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy);

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2cmem_pkg::*;
#(
    parameter int AW  = 10,
    parameter int PAW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic              wp,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wb_en,
    output logic [PAW-1:0]    wb_off,
    output logic [7:0]        wb_data,
    output logic              buf_clr,
    output logic [AW-PAW-1:0] base,
    output logic              commit,
    output logic              sda_low
);
    localparam logic [AW-1:0]  A_ONE = 1;
    localparam logic [PAW-1:0] P_ONE = 1;

    slv_state_e    state, next_st;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg, addr_hi, txreg;
    logic [AW-1:0] addr;
    logic          mack, dirty;
    logic [15:0]   full_addr;
    logic [3:0]    tx_sel;
    logic [2:0]    tx_idx;
    logic          unused_addr_bits;

    assign full_addr        = {addr_hi, shreg};
    assign unused_addr_bits = ^full_addr;
    assign tx_sel           = 4'd7 - bitcnt;
    assign tx_idx           = tx_sel[2:0];
    assign rd_addr          = addr;
    assign base             = addr[AW-1:PAW];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            next_st <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            addr_hi <= '0;
            txreg   <= '0;
            addr    <= '0;
            mack    <= 1'b0;
            dirty   <= 1'b0;
            sda_low <= 1'b0;
            wb_en   <= 1'b0;
            wb_off  <= '0;
            wb_data <= '0;
            buf_clr <= 1'b0;
            commit  <= 1'b0;
        end else begin
            wb_en   <= 1'b0;
            buf_clr <= 1'b0;
            commit  <= 1'b0;
            if (ev.start) begin
                state   <= ST_CTRL;
                bitcnt  <= '0;
                sda_low <= 1'b0;
                dirty   <= 1'b0;
            end else if (ev.stop) begin
                commit  <= dirty;
                dirty   <= 1'b0;
                state   <= ST_IDLE;
                bitcnt  <= '0;
                sda_low <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (ev.rise) begin
                    bitcnt <= bitcnt + 4'd1;
                    shreg  <= {shreg[6:0], ev.sda};
                    if (bitcnt == 4'd8)
                        mack <= !ev.sda;
                end else if (ev.fall) begin
                    if (state == ST_RD) begin
                        if (bitcnt == 4'd9) begin
                            bitcnt <= '0;
                            if (mack) begin
                                txreg   <= rd_data;
                                sda_low <= !rd_data[7];
                                addr    <= addr + A_ONE;
                            end else begin
                                sda_low <= 1'b0;
                                state   <= ST_IDLE;
                            end
                        end else if (bitcnt == 4'd8) begin
                            sda_low <= 1'b0;
                        end else if (bitcnt != 4'd0) begin
                            sda_low <= !txreg[tx_idx];
                        end
                    end else if (bitcnt == 4'd8) begin
                        sda_low <= 1'b1;
                        case (state)
                            ST_CTRL: begin
                                if (ctrl_match(shreg, strap) && !busy) begin
                                    next_st <= shreg[0] ? ST_RD : ST_AHI;
                                end else begin
                                    sda_low <= 1'b0;
                                    next_st <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                addr_hi <= shreg;
                                next_st <= ST_ALO;
                            end
                            ST_ALO: begin
                                addr    <= full_addr[AW-1:0];
                                buf_clr <= 1'b1;
                                next_st <= ST_WR;
                            end
                            ST_WR: begin
                                wb_en   <= !is_guarded(addr[AW-1 -: 2], wp);
                                wb_off  <= addr[PAW-1:0];
                                wb_data <= shreg;
                                dirty   <= 1'b1;
                                addr    <= {addr[AW-1:PAW], addr[PAW-1:0] + P_ONE};
                                next_st <= ST_WR;
                            end
                            default: begin
                                sda_low <= 1'b0;
                                next_st <= ST_IDLE;
                            end
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        state   <= next_st;
                        bitcnt  <= '0;
                        sda_low <= 1'b0;
                        if (next_st == ST_RD) begin
                            txreg   <= rd_data;
                            sda_low <= !rd_data[7];
                            addr    <= addr + A_ONE;
                        end
                    end
                end
            end
        end
    end

    // R6: the data line moves only right after a low-going SCL or a bus condition
    assert_sda_edge_R6: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_low) |-> $past(ev.fall || ev.start || ev.stop));

    // R2: outside a read, the line is pulled only in the acknowledge slot
    assert_ack_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (sda_low && state != ST_RD) |-> (bitcnt >= 4'd8));

    // R1: an idle block never holds the line
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_low);

    // R5: a control byte seen during the busy window is refused
    assert_busy_nack_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CTRL && ev.fall && bitcnt == 4'd8 && busy) |=> !sda_low);

endmodule

// File: rtl/i2c_serial_mem.sv
module i2c_serial_mem
    import i2cmem_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int PAGE_AW     = 5,
    parameter int BUSY_CYC    = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_low,
    input  logic [2:0] addr_strap,
    input  logic       wp_in
);
    bus_ev_t                   ev;
    logic                      busy, wb_en, buf_clr, commit;
    logic [PAGE_AW-1:0]        wb_off;
    logic [7:0]                wb_data, rd_data;
    logic [MEM_AW-PAGE_AW-1:0] base;
    logic [MEM_AW-1:0]         rd_addr;

    i2c_bus_sampler #(.SYNC(SYNC_STAGES)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_slave_fsm #(.AW(MEM_AW), .PAW(PAGE_AW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (addr_strap),
        .wp      (wp_in),
        .busy    (busy),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wb_en   (wb_en),
        .wb_off  (wb_off),
        .wb_data (wb_data),
        .buf_clr (buf_clr),
        .base    (base),
        .commit  (commit),
        .sda_low (sda_low)
    );

    i2c_page_store #(.AW(MEM_AW), .PAW(PAGE_AW), .BUSY_CYC(BUSY_CYC)) u_store (
        .clk     (clk),
        .rst     (rst),
        .buf_clr (buf_clr),
        .wb_en   (wb_en),
        .wb_off  (wb_off),
        .wb_data (wb_data),
        .commit  (commit),
        .base    (base),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy)
    );

endmodule

// File: tb/tb_i2c_serial_mem.sv
module tb_i2c_serial_mem;
    localparam int AW   = 8;
    localparam int PAW  = 5;
    localparam int BUSY = 400;
    localparam int N    = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       wp = 1'b0;
    logic [2:0] strap = 3'd0;
    logic       sda_low, sda_line;
    logic [7:0] model [N];
    int         n_chk = 0;
    int         n_fail = 0;
    int         cyc = 0;
    logic       done = 1'b0;

    assign sda_line = !(m_low || sda_low);

    always #4 clk = ~clk;

    i2c_serial_mem #(.MEM_AW(AW), .PAGE_AW(PAW), .BUSY_CYC(BUSY)) dut (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .sda_low    (sda_low),
        .addr_strap (strap),
        .wp_in      (wp)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 195000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=%0d expected<%0d cycles", cyc, 195000);
            report();
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dv(input int a, input logic [7:0] salt);
        return 8'(a * 29) ^ salt;
    endfunction

    task automatic wq();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq();
        scl = 1'b1; wq();
        m_low = 1'b1; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        scl = 1'b1; wq();
        m_low = 1'b0; wq();
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; wq();
        scl = 1'b1; wq();
        b = sda_line; wq();
        scl = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!give_ack);
    endtask

    task automatic write_run(input int a, input int n, input logic [7:0] salt, input string req);
        logic ack;
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, ack);
        chk(ack, "R2 write control", int'(ack), 1);
        wr_byte(8'hE0, ack);
        wr_byte(8'(a), ack);
        chk(ack, "R3 address", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            int ad;
            logic [7:0] d;
            ad = (a & ~31) | (((a & 31) + i) & 31);
            d  = dv(ad, salt);
            wr_byte(d, ack);
            chk(ack, req, int'(ack), 1);
            if (!(wp && ad >= 192)) model[ad] = d;
        end
        bus_stop();
        repeat (BUSY + 20) @(negedge clk);
    endtask

    task automatic read_run(input int a, input int n, input string req);
        logic       ack;
        logic [7:0] d;
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'(a), ack);
        bus_start();
        wr_byte({4'b1010, strap, 1'b1}, ack);
        chk(ack, "R6 read control", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(d, i != n - 1);
            chk(d == model[(a + i) % N], req, int'(d), int'(model[(a + i) % N]));
        end
        chk(!sda_low, "R7 released after NACK", int'(sda_low), 0);
        bus_stop();
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!sda_low, "R1 reset state", int'(sda_low), 0);
        chk(sda_line, "R1 line released", int'(sda_line), 1);

        // R2: every strap value against every address in the control byte
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int a = 0; a < 8; a++) begin
                bus_start();
                wr_byte({4'b1010, 3'(a), 1'b0}, ack);
                chk(ack == (a == s), "R2 strap match", int'(ack), int'(a == s));
                bus_stop();
            end
        end
        strap = 3'd3;

        // R2: wrong device type, then R1: no START means no acknowledge
        bus_start();
        wr_byte({4'b1011, strap, 1'b0}, ack);
        chk(!ack, "R2 wrong type", int'(ack), 0);
        wr_byte({4'b1010, strap, 1'b0}, ack);
        chk(!ack, "R1 no START", int'(ack), 0);
        chk(!sda_low, "R1 idle", int'(sda_low), 0);
        bus_stop();

        // R4 R3 R7: fill the whole array page by page, then read it back in one run
        for (int p = 0; p < N / 32; p++) write_run(p * 32, 32, 8'h5A, "R4 page data ack");
        read_run(0, N, "R3 R7 full sweep");

        // R5: polling during the busy window
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h10, ack);
        wr_byte(8'hC3, ack);
        bus_stop();
        model[16] = 8'hC3;
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, ack);
        chk(!ack, "R5 busy refuses control", int'(ack), 0);
        bus_stop();
        repeat (BUSY + 20) @(negedge clk);
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, ack);
        chk(ack, "R5 ready after window", int'(ack), 1);
        bus_stop();
        read_run(16, 1, "R5 committed data");

        // R4: wrap inside the page
        write_run(8'h5E, 4, 8'h21, "R4 wrap ack");
        read_run(8'h40, 32, "R4 page wrap");

        // R7: wrap at the end of the array and current-address continuation
        read_run(8'hFE, 3, "R7 array wrap");
        bus_start();
        wr_byte({4'b1010, strap, 1'b1}, ack);
        rd_byte(d, 1'b0);
        chk(d == model[1], "R7 current address", int'(d), int'(model[1]));
        bus_stop();

        // R8: write guard on the top quarter
        wp = 1'b1;
        write_run(8'hC0, 4, 8'h33, "R8 guarded ack");
        write_run(8'h80, 2, 8'h44, "R8 unguarded ack");
        read_run(8'hC0, 4, "R8 guarded unchanged");
        read_run(8'h80, 2, "R8 unguarded stored");
        wp = 1'b0;
        write_run(8'hC0, 2, 8'h77, "R8 open ack");
        read_run(8'hC0, 2, "R8 open stored");

        done = 1'b1;
        report();
    end

endmodule